// File: doc/BRIEF.md
# Infrared Pulse-Position Command Sender

This block sends one 8-bit command byte as an infrared frame. The byte encodes the value in the gaps between marks. A host pulses `start` for one clock with the byte on `payload`. The block then copies the byte, raises `busy`, and drives the active-low pin `ir_n` through the whole frame. The byte normally comes from a general-purpose register. It names the vector that the far-end device jumps to.

A frame has nine marks of equal length with eight spaces between them:

- The first mark is the leader.
- Each space carries one payload bit, least significant bit first. A short space means 0 and a long space means 1.
- The mark after the last space is the stop mark.

A clock divider makes a carrier that is low for about a third of each period. While `carrier_en` is 1, every mark is built by gating this carrier. While it is 0, each mark is a solid low level. A source-select input gives the pin to this encoder, or to a plain software-driven level.

All durations are counted in carrier periods. The defaults suit a 3.04 MHz clock: a 38 kHz carrier, a 21-period mark or short space (about 560 µs), and a 64-period long space (about 1690 µs).

Top module: `ir_ppm_tx`

## Requirements
- R1: After reset, with `hw_select`=1, `ir_n` is 1 and `busy` is 0.
- R2: A frame is a mark, then for each payload bit 0 to 7 in order a space followed by a mark. Each mark lasts MARK_P carrier periods. A space lasts SPACE0_P periods for a 0 bit and SPACE1_P periods for a 1 bit. `ir_n` is 1 during every space.
- R3: With `carrier_en`=1, a mark drives `ir_n` to 0 for the first ON clocks of each DIV-clock carrier period and to 1 for the rest. Carrier periods start on the first clock after the accepted strobe.
- R4: With `carrier_en`=0, `ir_n` is 0 for the whole of every mark.
- R5: With `hw_select`=1 and no frame in progress, `ir_n` is 1.
- R6: `busy` rises in the cycle after a strobe that is accepted. It stays 1 for exactly (9·MARK_P + Σ space lengths)·DIV clocks.
- R7: A strobe while `busy`=1 is ignored. The running frame keeps its waveform and its length.
- R8: With `hw_select`=0, `ir_n` equals `sw_level` at all times, frame or no frame.
- R9: The payload is captured on the accepted strobe. Later changes on `payload` do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-clock strobe that starts a frame |
| payload | input | 8 | Command byte to send |
| carrier_en | input | 1 | 1: gate marks with the carrier; 0: solid marks |
| hw_select | input | 1 | 1: encoder drives the pin; 0: `sw_level` drives it |
| sw_level | input | 1 | Level driven onto the pin by software |
| ir_n | output | 1 | Infrared output, active low |
| busy | output | 1 | High while a frame is being sent |

## Verification
The bench sends every one of the 256 byte values twice, once with the carrier on and once with it off. Each run is compared clock by clock against a waveform that the bench builds on its own from the segment lengths.

- The full byte sweep tells a swapped bit order or a wrong short/long choice apart from a correct encoding.
- The two carrier settings separate gated marks from solid ones.
- A frame that receives a second strobe and a payload change in mid-flight shows that neither restarts the frame nor recaptures the byte.
- Toggling `sw_level` with the encoder deselected, both idle and during a frame, confirms the pin follows the software level alone.

// File: rtl/ir_ppm_tx.sv
module ir_ppm_tx #(
  parameter int DIV      = 80,
  parameter int ON       = 27,
  parameter int MARK_P   = 21,
  parameter int SPACE0_P = 21,
  parameter int SPACE1_P = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] payload,
  input  logic       carrier_en,
  input  logic       hw_select,
  input  logic       sw_level,
  output logic       ir_n,
  output logic       busy
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int MAXP  = (MARK_P > SPACE0_P) ? ((MARK_P > SPACE1_P) ? MARK_P : SPACE1_P)
                                             : ((SPACE0_P > SPACE1_P) ? SPACE0_P : SPACE1_P);
  localparam int LEN_W = $clog2(MAXP + 1);

  logic [DIV_W-1:0] div;
  logic [LEN_W-1:0] pcnt, seg_last;
  logic [7:0]       shreg;
  logic [3:0]       bit_idx;
  logic             is_mark, busy_q;

  wire tick     = busy_q && (div == DIV_W'(DIV - 1));
  wire seg_done = tick && (pcnt == seg_last);
  wire car_low  = div < DIV_W'(ON);
  wire enc_n    = !(busy_q && is_mark && (car_low || !carrier_en));

  always_comb
    if (is_mark)       seg_last = LEN_W'(MARK_P - 1);
    else if (shreg[0]) seg_last = LEN_W'(SPACE1_P - 1);
    else               seg_last = LEN_W'(SPACE0_P - 1);

  assign ir_n = hw_select ? enc_n : sw_level;
  assign busy = busy_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q  <= 1'b0;
      is_mark <= 1'b0;
      bit_idx <= '0;
      pcnt    <= '0;
      div     <= '0;
      shreg   <= '0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      is_mark <= 1'b1;
      bit_idx <= '0;
      pcnt    <= '0;
      div     <= '0;
      shreg   <= payload;
    end else if (busy_q) begin
      div <= tick ? '0 : div + 1'b1;
      if (tick) pcnt <= seg_done ? '0 : pcnt + 1'b1;
      if (seg_done) begin
        if (is_mark) begin
          if (bit_idx == 4'd8) busy_q  <= 1'b0;
          else                 is_mark <= 1'b0;
        end else begin
          is_mark <= 1'b1;
          shreg   <= shreg >> 1;
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R6
  AST_SPACE_HIGH:   assert property (@(posedge clk) disable iff (!rst_n)
    busy && !is_mark && hw_select |-> ir_n); // R2
  AST_SOLID_MARK:   assert property (@(posedge clk) disable iff (!rst_n)
    busy && is_mark && !carrier_en && hw_select |-> !ir_n); // R4
  AST_IDLE_HIGH:    assert property (@(posedge clk) disable iff (!rst_n)
    !busy && hw_select |-> ir_n); // R5
  AST_NO_RESTART:   assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && bit_idx != 4'd0 |=> bit_idx != 4'd0); // R7
  AST_BIT_RANGE:    assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= 4'd8); // R2
  AST_DIV_BOUND:    assert property (@(posedge clk) disable iff (!rst_n)
    div < DIV_W'(DIV)); // R3
endmodule

// File: tb/ir_ppm_tx_test.sv
module ir_ppm_tx_test;
  localparam int D = 3, ON = 1, MK = 2, S0 = 2, S1 = 5;

  logic clk = 0, rst_n = 0, start = 0, carrier_en = 1, hw_select = 1, sw_level = 0;
  logic [7:0] payload = 0;
  logic ir_n, busy;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ir_ppm_tx #(.DIV(D), .ON(ON), .MARK_P(MK), .SPACE0_P(S0), .SPACE1_P(S1)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .payload(payload), .carrier_en(carrier_en),
    .hw_select(hw_select), .sw_level(sw_level), .ir_n(ir_n), .busy(busy));

  function automatic int frame_len(logic [7:0] p);
    int n = 9 * MK;
    for (int i = 0; i < 8; i++) n += p[i] ? S1 : S0;
    return n * D;
  endfunction

  function automatic logic exp_ir(int t, logic [7:0] p, logic car);
    int base = 0;
    for (int k = 0; k < 17; k++) begin
      int len = (k % 2 == 0) ? MK * D : (p[k/2] ? S1 : S0) * D;
      if (t < base + len) begin
        if (k % 2 == 1) return 1'b1;
        return car ? ((t % D) < ON ? 1'b0 : 1'b1) : 1'b0;
      end
      base += len;
    end
    return 1'b1;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Sends one frame and compares every clock; disturb=1 adds a strobe and payload change mid-frame.
  task automatic run_frame(logic [7:0] p, logic car, bit disturb, string req);
    int tot = frame_len(p);
    int bad_ir = 0, bad_busy = 0;
    logic fa = 1, fb = 1;
    carrier_en = car;
    payload = p;
    start = 1;
    @(negedge clk);
    start = 0;
    if (disturb) payload = ~p;
    for (int t = 0; t < tot + 4; t++) begin
      if (ir_n !== exp_ir(t, p, car) && bad_ir == 0) begin bad_ir = t + 1; fa = ir_n; end
      if (busy !== (t < tot) && bad_busy == 0) begin bad_busy = t + 1; fb = busy; end
      if (disturb && t == 7) begin start = 1; payload = 8'h5A; end
      if (disturb && t == 8) start = 0;
      @(negedge clk);
    end
    checks += 2;
    if (bad_ir != 0) begin
      errors++;
      $display("FAIL %s ir_n p=%02h car=%0b t=%0d actual=%0b expected=%0b",
               req, p, car, bad_ir - 1, fa, exp_ir(bad_ir - 1, p, car));
    end
    if (bad_busy != 0) begin
      errors++;
      $display("FAIL R6 busy p=%02h t=%0d actual=%0b expected=%0b",
               p, bad_busy - 1, fb, (bad_busy - 1) < tot);
    end
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ir_n", ir_n, 1'b1);
    check("R1 busy", busy, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R5 idle", ir_n, 1'b1);

    for (int p = 0; p < 256; p++) begin
      run_frame(8'(p), 1'b1, 0, "R2 R3");
      run_frame(8'(p), 1'b0, 0, "R2 R4");
    end

    run_frame(8'hC3, 1'b1, 1, "R7 R9");
    run_frame(8'h0F, 1'b0, 1, "R7 R9");
    check("R5 after", ir_n, 1'b1);

    hw_select = 0;
    for (int i = 0; i < 4; i++) begin
      sw_level = i[0];
      @(negedge clk);
      check("R8 idle", ir_n, sw_level);
    end
    payload = 8'hFF; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 12; i++) begin
      sw_level = i[1];
      @(negedge clk);
      check("R8 frame", ir_n, sw_level);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule